// File: doc/BRIEF.md
# Keyed Register Write Protection Guard

This block sits between a peripheral's register write path and its configuration registers. It decodes every bus write, decides whether the targeted register may be updated, and hands out a one-hot write-allow strobe for the chosen register. Protection is switched by a guard register. That register holds an enable bit and a 24-bit key field. The enable bit moves only when a write to the guard register carries the unlock key in its upper bits. The key field never reads back.

While protection is on, writes aimed at the configuration registers are dropped. These are the mode, rate, display and two segment-map registers. Each dropped write raises a violation flag in a log register, which also records the address offset of the first dropped write. Command and interrupt enable/disable writes pass at all times. A read strobe on the log register clears the log, so software sees each burst of violations once.

Top module: `regwr_guard`

## Requirements
- R1: After synchronous reset, the guard word, the log word and every write-allow bit are zero.
- R2: The guard word shows the enable bit at bit 0, and all other bits, including the key field at bits 31:8, read as zero.
- R3: A write to offset 0x0E0 whose bits 31:8 equal 0x4C4344 loads bit 0 of the write data into the enable bit, visible the cycle after the write.
- R4: A write to offset 0x0E0 whose bits 31:8 hold any other value leaves the enable bit unchanged.
- R5: With protection off, a write to one of the eight target offsets 0x000, 0x004, …, 0x01C raises wr_allow bit (offset/4) in the same cycle, and no other bit. The targets are command, mode, rate, display, map0, map1, interrupt-enable and interrupt-disable.
- R6: With protection on, writes to mode, rate, display, map0 and map1 (bits 1 to 5) give no write-allow bit and set the log flag.
- R7: Writes to command, interrupt-enable and interrupt-disable (bits 0, 6 and 7) are allowed whatever the protection state and never touch the log.
- R8: The log word has the flag at bit 0 and the source field at bits 23:8. The source holds the offset of the first blocked write since the last clear, and later blocked writes do not overwrite it.
- R9: A log read strobe clears flag and source the cycle after. If a blocked write arrives in the same cycle as the read, the log holds that write (flag 1, its offset) instead.
- R10: Writes to any offset outside the target list, the guard and the log offsets raise no write-allow bit and leave the log unchanged. Writes to the log offset also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| log_rd | input | 1 | Read strobe of the log register (clear on read) |
| wr_allow | output | 8 | One-hot write enable per target register |
| guard_word | output | 32 | Readable guard register value |
| log_word | output | 32 | Readable violation log value |

## Verification
Assertions check the following on every cycle. No lockable register is enabled while the guard bit is set. A wrong key never moves the enable bit, and a right one loads it. Always-open registers always get their strobe. The stored source survives later violations, and a lone read empties the log. The bench sweeps every target under both protection states and every single-bit corruption of the key. It also covers first-offender capture across a run of blocked writes and the same-cycle read/violation collision. Expected values for all of these are computed from the offset arithmetic.

// File: rtl/regwr_guard_pkg.sv
package regwr_guard_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 24;
  localparam int SRC_W  = 16;
  localparam int N_TGT  = 8;
  localparam int KEY_LO = DATA_W - KEY_W;

  localparam logic [KEY_W-1:0]  UNLOCK_KEY = 24'h4C4344;
  localparam logic [ADDR_W-1:0] GUARD_OFS  = 16'h00E0;
  localparam logic [ADDR_W-1:0] LOG_OFS    = 16'h00E4;

  typedef enum logic [2:0] {
    T_CMD, T_MODE, T_RATE, T_DISP, T_MAP0, T_MAP1, T_IEN, T_IDIS
  } tgt_e;

  // targets that the guard may lock: mode, rate, display, map0, map1
  localparam logic [N_TGT-1:0] LOCKABLE = 8'b0011_1110;

  function automatic logic [ADDR_W-1:0] tgt_offset(input int idx);
    return ADDR_W'(idx * 4);
  endfunction
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import regwr_guard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [N_TGT-1:0]  tgt_hit,
  output logic              guard_hit
);
  for (genvar i = 0; i < N_TGT; i++) begin : g_hit
    assign tgt_hit[i] = (addr == tgt_offset(i));
  end
  assign guard_hit = (addr == GUARD_OFS);
endmodule

// File: rtl/wp_keyreg.sv
module wp_keyreg
  import regwr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prot_en
);
  logic key_ok;
  assign key_ok = (wr_data[DATA_W-1:KEY_LO] == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst)                  prot_en <= 1'b0;
    else if (wr_stb && key_ok) prot_en <= wr_data[0];
  end

  // R4
  bad_key_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_data[DATA_W-1:KEY_LO] != UNLOCK_KEY) |=> (prot_en == $past(prot_en)));

  // R3
  good_key_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_data[DATA_W-1:KEY_LO] == UNLOCK_KEY) |=> (prot_en == $past(wr_data[0])));
endmodule

// File: rtl/wp_log.sv
module wp_log
  import regwr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              viol,
  input  logic [ADDR_W-1:0] viol_addr,
  input  logic              rd_clr,
  output logic              flag,
  output logic [SRC_W-1:0]  src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      src  <= '0;
    end else if (viol) begin
      flag <= 1'b1;
      if (!flag || rd_clr) src <= SRC_W'(viol_addr);
    end else if (rd_clr) begin
      flag <= 1'b0;
      src  <= '0;
    end
  end

  // R6
  viol_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    viol |=> flag);

  // R8
  keep_first_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && viol && !rd_clr) |=> (src == $past(src)));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !viol) |=> (!flag && src == '0));
endmodule

// File: rtl/regwr_guard.sv
module regwr_guard
  import regwr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              log_rd,
  output logic [N_TGT-1:0]  wr_allow,
  output logic [DATA_W-1:0] guard_word,
  output logic [DATA_W-1:0] log_word
);
  logic [N_TGT-1:0] tgt_hit;
  logic             guard_hit;
  logic             prot_en;
  logic             blocked;
  logic             log_flag;
  logic [SRC_W-1:0] log_src;
  logic [N_TGT-1:0] lock_mask;

  wp_decode u_dec (
    .addr      (wr_addr),
    .tgt_hit   (tgt_hit),
    .guard_hit (guard_hit)
  );

  wp_keyreg u_key (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_en && guard_hit),
    .wr_data (wr_data),
    .prot_en (prot_en)
  );

  assign lock_mask = prot_en ? LOCKABLE : '0;
  assign blocked   = wr_en && |(tgt_hit & lock_mask);
  assign wr_allow  = wr_en ? (tgt_hit & ~lock_mask) : '0;

  wp_log u_log (
    .clk       (clk),
    .rst       (rst),
    .viol      (blocked),
    .viol_addr (wr_addr),
    .rd_clr    (log_rd),
    .flag      (log_flag),
    .src       (log_src)
  );

  assign guard_word = {{(DATA_W-1){1'b0}}, prot_en};
  assign log_word   = {{(DATA_W-SRC_W-8){1'b0}}, log_src, 7'b0, log_flag};

  // R6
  locked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    guard_word[0] |-> ((wr_allow & LOCKABLE) == '0));

  // R7
  cmd_open_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == tgt_offset(T_CMD)) |-> wr_allow[T_CMD]);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_allow == '0));

  // R5
  allow_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_allow));
endmodule

// File: tb/regwr_guard_bench.sv
`timescale 1ns/1ps
module regwr_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        log_rd = 1'b0;
  logic [7:0]  wr_allow;
  logic [31:0] guard_word;
  logic [31:0] log_word;

  int checks = 0;
  int errors = 0;
  localparam logic [23:0] KEY = 24'h4C4344;
  localparam logic [7:0]  LOCKS = 8'b0011_1110;

  always #2 clk = ~clk;

  regwr_guard u_regwr_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .log_rd(log_rd), .wr_allow(wr_allow),
    .guard_word(guard_word), .log_word(log_word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] log_exp(input bit f, input logic [15:0] s);
    return {8'h0, s, 7'h0, f};
  endfunction

  // one bus cycle; allow sampled mid-cycle, registers settled on return
  task automatic bus(input bit we, input logic [15:0] a, input logic [31:0] d,
                     input bit rd, output logic [7:0] allow);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; log_rd = rd;
    #1 allow = wr_allow;
    @(posedge clk);
    #1 wr_en = 1'b0; log_rd = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] al;
    bit         fl;
    logic [15:0] src;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(guard_word == 0, "R1 guard", guard_word, 0);
    chk(log_word == 0, "R1 log", log_word, 0);
    chk(wr_allow == 0, "R1 allow", {24'h0, wr_allow}, 0);

    // R5 unlocked sweep over all targets
    for (int i = 0; i < 8; i++) begin
      bus(1'b1, 16'(i * 4), 32'hA5A5_0000 + i, 1'b0, al);
      chk(al == 8'(1 << i), "R5 unlocked allow", {24'h0, al}, 32'(1 << i));
      chk(log_word == 0, "R7 no log when unlocked", log_word, 0);
    end

    // R10 unmapped offsets and the log offset
    bus(1'b1, 16'h0100, 32'hFFFF_FFFF, 1'b0, al);
    chk(al == 0, "R10 unmapped allow", {24'h0, al}, 0);
    bus(1'b1, 16'h00E4, 32'hFFFF_FFFF, 1'b0, al);
    chk(al == 0 && log_word == 0, "R10 log offset write", log_word, 0);

    // R4 every single-bit key corruption is rejected
    for (int b = 0; b < 24; b++) begin
      bus(1'b1, 16'h00E0, {KEY ^ 24'(1 << b), 8'h01}, 1'b0, al);
      chk(guard_word == 0, "R4 bad key", guard_word, 0);
    end

    // R3 R2 correct key enables, key field reads zero
    bus(1'b1, 16'h00E0, {KEY, 8'hFF}, 1'b0, al);
    chk(guard_word == 32'h1, "R3 R2 enable", guard_word, 32'h1);

    // R6 R7 R8 locked sweep
    fl = 1'b0; src = '0;
    for (int i = 0; i < 8; i++) begin
      bus(1'b1, 16'(i * 4), 32'h1234_0000 + i, 1'b0, al);
      if (LOCKS[i]) begin
        chk(al == 0, "R6 locked allow", {24'h0, al}, 0);
        if (!fl) src = 16'(i * 4);
        fl = 1'b1;
      end else begin
        chk(al == 8'(1 << i), "R7 open allow", {24'h0, al}, 32'(1 << i));
      end
      chk(log_word == log_exp(fl, src), "R8 log content", log_word, log_exp(fl, src));
    end
    chk(log_word == log_exp(1'b1, 16'h0004), "R8 first offender", log_word, log_exp(1'b1, 16'h0004));

    // R9 read clears
    bus(1'b0, 16'h0000, 32'h0, 1'b1, al);
    chk(log_word == 0, "R9 clear on read", log_word, 0);

    // R9 collision: blocked write with read in the same cycle
    bus(1'b1, 16'h0014, 32'h0, 1'b0, al);
    bus(1'b1, 16'h000C, 32'h0, 1'b1, al);
    chk(log_word == log_exp(1'b1, 16'h000C), "R9 collision", log_word, log_exp(1'b1, 16'h000C));
    bus(1'b0, 16'h0000, 32'h0, 1'b1, al);
    chk(log_word == 0, "R9 clear again", log_word, 0);

    // R4 wrong key cannot disable
    bus(1'b1, 16'h00E0, {24'h4C4345, 8'h00}, 1'b0, al);
    chk(guard_word == 32'h1, "R4 hold enabled", guard_word, 32'h1);

    // R3 correct key disables; R5 mode writable again
    bus(1'b1, 16'h00E0, {KEY, 8'h00}, 1'b0, al);
    chk(guard_word == 0, "R3 disable", guard_word, 0);
    bus(1'b1, 16'h0004, 32'h0, 1'b0, al);
    chk(al == 8'h02 && log_word == 0, "R5 mode after unlock", {24'h0, al}, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule